// File: doc/BRIEF.md
# FP4 E2M1 Quantize-Dequantize Unit

This block takes one signed fixed-point element and one unsigned block scale per cycle. It rounds the ratio of the element's magnitude to the scale onto the eight FP4 E2M1 magnitude levels {0, 0.5, 1, 1.5, 2, 3, 4, 6}. It returns two results: a 4-bit code and the reconstructed value sign·q·s. The block has no divider. Each of the seven decision boundaries (the midpoints 0.25, 0.75, 1.25, 1.75, 2.5, 3.5 and 5.0) is tested as `4·|x| <= b4·s`, where b4 is one of 1, 3, 5, 7, 10, 14 and 20. All seven tests run on every element. A fixed priority chain then picks the level, so no control flow depends on the data.

The element and the scale share one fixed-point format. The reconstructed value has one more fractional bit than the scale, so its LSB is half a scale LSB. It is wide enough to hold ±6·s exactly. The parameter `CMP_REG` selects one of two pipeline depths. When it is 1, a register stage sits between the comparator bank and the selector. When it is 0, the comparison and the selection finish in a single cycle.

Top module: `fp4q_unit`

## Requirements
- R1: `out_code[2:0]` is the index 0..7 into the levels {0, 0.5, 1, 1.5, 2, 3, 4, 6}. It selects the level nearest to |x|/s.
- R2: A ratio that lies exactly on a boundary (`4·|x| == b4·s`) selects the smaller of the two neighbouring levels.
- R3: A ratio above 5.0 (`4·|x| > 20·s`) saturates to index 7, the level 6.
- R4: `out_value` is a two's-complement number in half-scale-LSB units. It equals ±(2q)·s exactly, and its sign follows the sign of x.
- R5: `out_code[3]` is set only when x is negative and the index is nonzero. Any result of magnitude zero gives code 0 and value 0.
- R6: A scale of zero forces `out_code` to 0 and `out_value` to 0, whatever the element is.
- R7: While reset is asserted, `out_valid`, `out_code` and `out_value` are all 0.
- R8: `out_valid` repeats `in_valid` after 1+`CMP_REG` clock edges. The block accepts one element on every cycle.
- R9: The most negative input, −2^(IN_W−1), is quantized from its true magnitude 2^(IN_W−1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Element valid |
| in_data | input | IN_W | Signed element, two's complement |
| in_scale | input | SC_W | Unsigned block scale, same format as the element |
| out_valid | output | 1 | Result valid |
| out_code | output | 4 | Sign in bit 3, level index in bits 2..0 |
| out_value | output | SC_W+5 | Reconstructed value, signed, LSB = half a scale LSB |

## Verification
The bench builds the unit with `IN_W = 8`, `SC_W = 6` and `CMP_REG = 1`. At this size every element from −128 to 127 can be paired with every scale from 0 to 63, so all 16384 combinations run through the pipeline. That sweep covers every exact boundary tie, the zero scale, saturation and the most negative element. Valid bubbles are mixed into the stream to show that results keep their order, and a single isolated element measures the latency.

// File: rtl/fp4q_pkg.sv
package fp4q_pkg;

   localparam int NUM_BND = 7;
   localparam int CODE_W  = 4;
   localparam int IDX_W   = 3;

   // Boundary times four: 0.25, 0.75, 1.25, 1.75, 2.5, 3.5, 5.0
   function automatic logic [4:0] bnd4(input int i);
      case (i)
         0:       bnd4 = 5'd1;
         1:       bnd4 = 5'd3;
         2:       bnd4 = 5'd5;
         3:       bnd4 = 5'd7;
         4:       bnd4 = 5'd10;
         5:       bnd4 = 5'd14;
         default: bnd4 = 5'd20;
      endcase
   endfunction

   // Level times two: 0, 0.5, 1, 1.5, 2, 3, 4, 6
   function automatic logic [3:0] lvl2(input logic [IDX_W-1:0] idx);
      case (idx)
         3'd0:    lvl2 = 4'd0;
         3'd1:    lvl2 = 4'd1;
         3'd2:    lvl2 = 4'd2;
         3'd3:    lvl2 = 4'd3;
         3'd4:    lvl2 = 4'd4;
         3'd5:    lvl2 = 4'd6;
         3'd6:    lvl2 = 4'd8;
         default: lvl2 = 4'd12;
      endcase
   endfunction

endpackage

// File: rtl/fp4q_cmp_bank.sv
module fp4q_cmp_bank #(
   parameter int IN_W = 16,
   parameter int SC_W = 16
) (
   input  logic [IN_W-1:0]                mag,
   input  logic [SC_W-1:0]                scale,
   output logic [fp4q_pkg::NUM_BND-1:0]   le
);
   localparam int CMP_W = (IN_W + 2 > SC_W + 5) ? IN_W + 2 : SC_W + 5;

   logic [CMP_W-1:0] lhs;
   assign lhs = CMP_W'({mag, 2'b00});

   for (genvar i = 0; i < fp4q_pkg::NUM_BND; i++) begin : g_cmp
      localparam logic [4:0] B4 = fp4q_pkg::bnd4(i);
      logic [CMP_W-1:0] rhs;
      assign rhs   = CMP_W'(scale) * CMP_W'(B4);
      assign le[i] = (lhs <= rhs);
   end
endmodule

// File: rtl/fp4q_select.sv
module fp4q_select (
   input  logic [fp4q_pkg::NUM_BND-1:0] le,
   output logic [fp4q_pkg::IDX_W-1:0]   idx
);
   // Lowest passing boundary wins; none passing saturates to the top level
   always_comb begin
      idx = 3'd7;
      for (int i = fp4q_pkg::NUM_BND - 1; i >= 0; i--) begin
         if (le[i]) idx = 3'(i);
      end
   end
endmodule

// File: rtl/fp4q_recon.sv
module fp4q_recon #(
   parameter int SC_W = 16
) (
   input  logic [fp4q_pkg::IDX_W-1:0]  idx,
   input  logic                        neg,
   input  logic                        szero,
   input  logic [SC_W-1:0]             scale,
   output logic [fp4q_pkg::CODE_W-1:0] code,
   output logic [SC_W+4:0]             value
);
   localparam int PROD_W = SC_W + 4;
   localparam int OUT_W  = SC_W + 5;

   logic              is_zero;
   logic [3:0]        lv;
   logic [PROD_W-1:0] prod;
   logic [OUT_W-1:0]  ext;

   assign is_zero = szero || (idx == 3'd0);
   assign lv      = szero ? 4'd0 : fp4q_pkg::lvl2(idx);
   assign prod    = PROD_W'(lv) * PROD_W'(scale);
   assign ext     = {1'b0, prod};
   assign code    = is_zero ? 4'd0 : {neg, idx};
   assign value   = (neg && !is_zero) ? (~ext + 1'b1) : ext;
endmodule

// File: rtl/fp4q_unit.sv
module fp4q_unit #(
   parameter int IN_W    = 16,
   parameter int SC_W    = 16,
   parameter bit CMP_REG = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic [IN_W-1:0] in_data,
   input  logic [SC_W-1:0] in_scale,
   output logic            out_valid,
   output logic [3:0]      out_code,
   output logic [SC_W+4:0] out_value
);
   localparam int OUT_W = SC_W + 5;
   localparam int NB    = fp4q_pkg::NUM_BND;

   if (IN_W < 2)  begin : g_bad_in  $error("fp4q_unit: IN_W must be at least 2");  end
   if (SC_W < 1)  begin : g_bad_sc  $error("fp4q_unit: SC_W must be at least 1");  end

   logic [IN_W-1:0] mag_c;
   logic [NB-1:0]   le_c;
   logic            neg_c;

   assign neg_c = in_data[IN_W-1];
   assign mag_c = neg_c ? (~in_data + 1'b1) : in_data;

   fp4q_cmp_bank #(.IN_W(IN_W), .SC_W(SC_W)) u_cmp (
      .mag   (mag_c),
      .scale (in_scale),
      .le    (le_c)
   );

   logic            s1_vld;
   logic            s1_neg;
   logic [NB-1:0]   s1_le;
   logic [SC_W-1:0] s1_scale;

   if (CMP_REG) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            s1_vld   <= 1'b0;
            s1_neg   <= 1'b0;
            s1_le    <= '0;
            s1_scale <= '0;
         end else begin
            s1_vld   <= in_valid;
            s1_neg   <= neg_c;
            s1_le    <= le_c;
            s1_scale <= in_scale;
         end
      end
   end else begin : g_flow
      assign s1_vld   = in_valid;
      assign s1_neg   = neg_c;
      assign s1_le    = le_c;
      assign s1_scale = in_scale;
   end

   logic [2:0]       idx_c;
   logic [3:0]       code_c;
   logic [OUT_W-1:0] val_c;

   fp4q_select u_sel (
      .le  (s1_le),
      .idx (idx_c)
   );

   fp4q_recon #(.SC_W(SC_W)) u_rec (
      .idx   (idx_c),
      .neg   (s1_neg),
      .szero (s1_scale == '0),
      .scale (s1_scale),
      .code  (code_c),
      .value (val_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_code  <= '0;
         out_value <= '0;
      end else begin
         out_valid <= s1_vld;
         out_code  <= code_c;
         out_value <= val_c;
      end
   end
endmodule

// File: rtl/fp4q_unit_chk.sv
module fp4q_unit_chk #(
   parameter int IN_W    = 16,
   parameter int SC_W    = 16,
   parameter bit CMP_REG = 1'b1
) (
   input logic            clk,
   input logic            rst_n,
   input logic            in_valid,
   input logic [IN_W-1:0] in_data,
   input logic [SC_W-1:0] in_scale,
   input logic            out_valid,
   input logic [3:0]      out_code,
   input logic [SC_W+4:0] out_value
);
   localparam int LAT = 1 + int'(CMP_REG);
   localparam int W   = IN_W + SC_W + 8;

   logic [IN_W:0] mag_k;
   logic          sat_now;
   logic          szero_now;

   assign mag_k     = in_data[IN_W-1] ? ((IN_W+1)'(1) << IN_W) - (IN_W+1)'(in_data)
                                      : (IN_W+1)'(in_data);
   assign szero_now = (in_scale == '0);
   assign sat_now   = !szero_now && ((W'(mag_k) * W'(4)) > (W'(in_scale) * W'(20)));

   p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(in_valid, LAT));

   p_zero_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_code[2:0] == 3'd0) |-> (out_code == 4'd0 && out_value == '0));

   p_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_code[3]) |-> $signed(out_value) < 0);

   p_zero_scale_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(szero_now, LAT)) |-> (out_code == 4'd0 && out_value == '0));

   p_saturate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(sat_now, LAT)) |-> out_code[2:0] == 3'd7);
endmodule

bind fp4q_unit fp4q_unit_chk #(.IN_W(IN_W), .SC_W(SC_W), .CMP_REG(CMP_REG)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_data   (in_data),
   .in_scale  (in_scale),
   .out_valid (out_valid),
   .out_code  (out_code),
   .out_value (out_value)
);

// File: tb/fp4q_unit_bench.sv
module fp4q_unit_bench;
   localparam int IN_W  = 8;
   localparam int SC_W  = 6;
   localparam int OUT_W = SC_W + 5;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             in_valid = 1'b0;
   logic [IN_W-1:0]  in_data = '0;
   logic [SC_W-1:0]  in_scale = '0;
   logic             out_valid;
   logic [3:0]       out_code;
   logic [OUT_W-1:0] out_value;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   int q_code[$];
   int q_val[$];
   int q_cat[$];

   always #5 clk = ~clk;

   fp4q_unit #(.IN_W(IN_W), .SC_W(SC_W), .CMP_REG(1'b1)) u_fp4q_unit (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .in_scale  (in_scale),
      .out_valid (out_valid),
      .out_code  (out_code),
      .out_value (out_value)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // cat: 1=R1 plain, 2=R2 tie, 3=R3 saturation, 6=R6 zero scale, 9=R9 most negative
   task automatic model(input int x, input int s, output int code, output int val, output int cat);
      int b4[7];
      int lv2[8];
      int m, idx;
      bit neg, tie;
      b4  = '{1, 3, 5, 7, 10, 14, 20};
      lv2 = '{0, 1, 2, 3, 4, 6, 8, 12};
      m   = (x < 0) ? -x : x;
      idx = 7;
      tie = 1'b0;
      for (int i = 6; i >= 0; i--) begin
         if (4 * m <= b4[i] * s) idx = i;
         if (4 * m == b4[i] * s) tie = 1'b1;
      end
      if (s == 0) begin
         code = 0; val = 0; cat = 6;
      end else begin
         neg  = (x < 0) && (idx != 0);
         code = (neg ? 8 : 0) + idx;
         val  = (neg ? -1 : 1) * lv2[idx] * s;
         if (x == -(1 << (IN_W - 1)))  cat = 9;
         else if (tie)                 cat = 2;
         else if (4 * m > 20 * s)      cat = 3;
         else                          cat = 1;
      end
   endtask

   function automatic string cat_name(input int cat);
      case (cat)
         2:       return "R2";
         3:       return "R3";
         6:       return "R6";
         9:       return "R9";
         default: return "R1";
      endcase
   endfunction

   task automatic pop_and_check();
      int ec, ev, cat;
      if (q_code.size() == 0) begin
         check("R8 unexpected out_valid", 1, 0);
         return;
      end
      ec  = q_code.pop_front();
      ev  = q_val.pop_front();
      cat = q_cat.pop_front();
      check(cat_name(cat), int'(out_code[2:0]), ec % 8);
      check("R5 sign bit", int'(out_code[3]), ec / 8);
      check("R4 value", int'($signed(out_value)), ev);
   endtask

   initial begin
      int ec, ev, cat, n;
      // Reset state (R7)
      repeat (3) @(negedge clk);
      check("R7 out_valid in reset", int'(out_valid), 0);
      check("R7 out_code in reset", int'(out_code), 0);
      check("R7 out_value in reset", int'(out_value), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // Latency with an isolated element (R8): x=6, s=4 -> ratio 1.5 -> idx 3, value 12
      in_valid = 1'b1; in_data = 8'd6; in_scale = 6'd4;
      @(negedge clk);
      in_valid = 1'b0;
      check("R8 not valid after one edge", int'(out_valid), 0);
      @(negedge clk);
      check("R8 valid after two edges", int'(out_valid), 1);
      check("R1 isolated code", int'(out_code), 3);
      check("R4 isolated value", int'($signed(out_value)), 12);
      @(negedge clk);
      check("R8 single pulse", int'(out_valid), 0);

      // Exhaustive sweep with bubbles
      n = 0;
      for (int s = 0; s < (1 << SC_W); s++) begin
         for (int x = -(1 << (IN_W - 1)); x < (1 << (IN_W - 1)); x++) begin
            if (n % 7 == 3) begin
               if (out_valid) pop_and_check();
               in_valid = 1'b0;
               @(negedge clk);
            end
            if (out_valid) pop_and_check();
            model(x, s, ec, ev, cat);
            q_code.push_back(ec);
            q_val.push_back(ev);
            q_cat.push_back(cat);
            in_valid = 1'b1;
            in_data  = IN_W'(x);
            in_scale = SC_W'(s);
            n++;
            @(negedge clk);
         end
      end
      in_valid = 1'b0;
      repeat (4) begin
         if (out_valid) pop_and_check();
         @(negedge clk);
      end
      check("R8 all results delivered", q_code.size(), 0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule